// File: doc/BRIEF.md
# Thread Interrupt Priority Update Logic

This block holds the interrupt context of one hardware thread across three rings: the OS ring, the hypervisor pool ring and the hypervisor physical ring. Each ring has a pending-priority bitmap, a current priority (CPPR), a pending priority (PIPR), a missed-group-backlog priority, a group-size byte and a context-valid bit. A side port loads the bitmap, backlog priority, group-size byte and valid bit of any ring.

Software writes a new CPPR to the OS ring or to the physical ring. The block clamps and stores that value, then recomputes the PIPR from the bitmap. On a physical-ring write it also merges in the pool ring when the pool context is valid. It then chooses the ring that holds the most favoured work and checks that this ring's context is valid. If a group interrupt may be waiting in the backlog, it asks an external model to scan the backlog through a request/acknowledge port. It applies the result and issues a backlog decrement when an interrupt was found. Finally it updates that ring's exception line.

A combinational check reports whether an incoming interrupt of a given priority would be taken now by a given ring.

Top module: `thr_prio_update`

## Requirements
- R1: After reset every ring has CPPR 0x00, PIPR 0xFF, backlog priority 0xFF, group-size 0, context invalid and an empty bitmap. All exception lines, `busy`, `scan_req`, `dec_req` and `ctx_err` are 0. Ring codes are 0 = OS, 1 = pool, 2 = physical; code 3 is unused.
- R2: A CPPR write (`wr_phys` 0 = OS ring, 1 = physical ring) with a value above 7 stores 0xFF. Values 0 to 7 are stored unchanged, and a lower value is a more favoured priority.
- R3: On a CPPR write the written ring's PIPR becomes the index of the most favoured set bit of its 8-bit bitmap, where bit 7 is priority 0 and bit 0 is priority 7. An empty bitmap gives 0xFF.
- R4: When an update completes on a valid context, the exception line `exc[ring]` of the selected ring becomes 1 if the written ring's final PIPR is below its CPPR, and 0 otherwise. Other exception lines keep their value.
- R5: On a physical-ring write the pool ring is merged only when the pool valid bit is set. If the pool PIPR is below the physical PIPR, it becomes the stored PIPR. The pool is then selected if that PIPR is also below the current backlog minimum.
- R6: A ring's group handling is on only when its group-size byte is nonzero; otherwise its backlog priority counts as 0xFF. A backlog scan is requested only when group handling is on and the backlog minimum is below both the new CPPR and the merged PIPR. Otherwise the update completes in the write cycle.
- R7: On a physical-ring write with a valid pool, the pool's backlog priority becomes the minimum when the pool group-size is nonzero and the value is smaller. This turns group handling on. The pool is selected if that minimum is below the merged PIPR.
- R8: If the selected ring's context is invalid, the block stores CPPR and PIPR, pulses `ctx_err` for one cycle, requests no scan and changes no exception line.
- R9: The scan result is written to the selected ring's backlog priority. If the result is not 0xFF, `dec_req` pulses for one cycle with that priority and the scan's group level, and the written ring's PIPR becomes the result.
- R10: `chk_ok` is 1 only when `chk_prio` is strictly below the CPPR of the checked ring. The pool ring is checked against the physical ring's CPPR, and ring code 3 always gives 0.
- R11: While a scan is outstanding, `busy` is 1, `scan_req` stays high until `scan_ack`, and CPPR writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load context fields of one ring |
| ld_ring | input | 2 | Ring to load |
| ld_pend | input | 8 | Pending-priority bitmap |
| ld_lsmfb | input | 8 | Missed group backlog priority |
| ld_lgs | input | 8 | Group-size byte |
| ld_valid | input | 1 | Context-valid bit |
| wr_en | input | 1 | CPPR write strobe |
| wr_phys | input | 1 | 0 = OS ring, 1 = physical ring |
| wr_val | input | 8 | CPPR value written |
| busy | output | 1 | Scan outstanding |
| scan_req | output | 1 | Backlog scan request |
| scan_ring | output | 2 | Ring whose context is scanned |
| scan_ack | input | 1 | Scan response valid |
| scan_prio | input | 8 | Scan result priority, 0xFF if none |
| scan_level | input | 4 | Group level of the result |
| dec_req | output | 1 | Backlog decrement pulse |
| dec_prio | output | 8 | Priority to decrement |
| dec_level | output | 4 | Group level to decrement |
| ctx_err | output | 1 | Invalid-context pulse |
| exc | output | 3 | Exception line per ring |
| rd_ring | input | 2 | Ring to observe |
| rd_cppr | output | 8 | CPPR of observed ring |
| rd_pipr | output | 8 | PIPR of observed ring |
| rd_lsmfb | output | 8 | Backlog priority of observed ring |
| chk_ring | input | 2 | Ring for preclusion check |
| chk_prio | input | 8 | Priority of incoming interrupt |
| chk_ok | output | 1 | Interrupt would be taken now |

## Verification
The hardest case to reach is a physical-ring write where the pool ring wins through its group backlog. This needs a valid pool context with an empty bitmap and a nonzero group-size, a backlog priority below both the physical PIPR and the new CPPR, and a pool exception line that is low beforehand. The bench reaches it in steps. It loads both rings, then writes CPPR 0 to clear the pool line without a scan, and only then writes the CPPR that triggers the scan. It answers the scan request by hand and checks the pool's backlog value, the merged PIPR and the pool exception line.

// File: rtl/thr_prio_update.sv
module thr_prio_update #(
  parameter int PW       = 8,
  parameter int PRIO_MAX = 7,
  parameter int LW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_ring,
  input  logic [PRIO_MAX:0] ld_pend,
  input  logic [PW-1:0] ld_lsmfb,
  input  logic [PW-1:0] ld_lgs,
  input  logic          ld_valid,
  input  logic          wr_en,
  input  logic          wr_phys,
  input  logic [PW-1:0] wr_val,
  output logic          busy,
  output logic          scan_req,
  output logic [1:0]    scan_ring,
  input  logic          scan_ack,
  input  logic [PW-1:0] scan_prio,
  input  logic [LW-1:0] scan_level,
  output logic          dec_req,
  output logic [PW-1:0] dec_prio,
  output logic [LW-1:0] dec_level,
  output logic          ctx_err,
  output logic [2:0]    exc,
  input  logic [1:0]    rd_ring,
  output logic [PW-1:0] rd_cppr,
  output logic [PW-1:0] rd_pipr,
  output logic [PW-1:0] rd_lsmfb,
  input  logic [1:0]    chk_ring,
  input  logic [PW-1:0] chk_prio,
  output logic          chk_ok
);
  localparam int NP = PRIO_MAX + 1;
  localparam logic [PW-1:0] MASK = {PW{1'b1}};
  localparam logic [1:0] R_OS = 2'd0, R_POOL = 2'd1, R_PHYS = 2'd2;

  logic [NP-1:0] pend_q  [3];
  logic [PW-1:0] cppr_q  [3];
  logic [PW-1:0] pipr_q  [3];
  logic [PW-1:0] lsmfb_q [3];
  logic [PW-1:0] lgs_q   [3];
  logic [2:0]    valid_q;
  logic [1:0]    sel_q;
  logic          tphys_q;

  function automatic logic [PW-1:0] first_prio(input logic [NP-1:0] p);
    logic [PW-1:0] r;
    r = MASK;
    for (int i = NP - 1; i >= 0; i--)
      if (p[NP-1-i]) r = PW'(i);
    return r;
  endfunction

  logic [1:0]    tgt;
  logic [PW-1:0] cppr_c, pipr_m, lm, pool_pipr;
  logic          ge, need_scan;
  logic [1:0]    sel;

  assign tgt       = wr_phys ? R_PHYS : R_OS;
  assign cppr_c    = (wr_val > PW'(PRIO_MAX)) ? MASK : wr_val;
  assign pool_pipr = first_prio(pend_q[R_POOL]);

  always_comb begin
    pipr_m = first_prio(pend_q[tgt]);
    ge     = lgs_q[tgt] != '0;
    lm     = ge ? lsmfb_q[tgt] : MASK;
    sel    = tgt;
    if (wr_phys && valid_q[R_POOL]) begin
      if (pool_pipr < pipr_m) begin
        pipr_m = pool_pipr;
        if (pool_pipr < lm) sel = R_POOL;
      end
      if (lgs_q[R_POOL] != '0 && lsmfb_q[R_POOL] < lm) begin
        ge = 1'b1;
        lm = lsmfb_q[R_POOL];
        if (lm < pipr_m) sel = R_POOL;
      end
    end
  end

  assign need_scan = ge && (lm < cppr_c) && (lm < pipr_m);

  logic [1:0] tq;
  assign tq = tphys_q ? R_PHYS : R_OS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 3; r++) begin
        pend_q[r]  <= '0;
        cppr_q[r]  <= '0;
        pipr_q[r]  <= MASK;
        lsmfb_q[r] <= MASK;
        lgs_q[r]   <= '0;
      end
      valid_q   <= '0;
      sel_q     <= R_OS;
      tphys_q   <= 1'b0;
      busy      <= 1'b0;
      dec_req   <= 1'b0;
      dec_prio  <= '0;
      dec_level <= '0;
      ctx_err   <= 1'b0;
      exc       <= '0;
    end else begin
      dec_req <= 1'b0;
      ctx_err <= 1'b0;
      if (ld_en && ld_ring != 2'd3) begin
        pend_q[ld_ring]  <= ld_pend;
        lsmfb_q[ld_ring] <= ld_lsmfb;
        lgs_q[ld_ring]   <= ld_lgs;
        valid_q[ld_ring] <= ld_valid;
      end
      if (!busy && wr_en) begin
        cppr_q[tgt] <= cppr_c;
        pipr_q[tgt] <= pipr_m;
        if (!valid_q[sel]) begin
          ctx_err <= 1'b1;
        end else if (need_scan) begin
          busy    <= 1'b1;
          sel_q   <= sel;
          tphys_q <= wr_phys;
        end else begin
          exc[sel] <= pipr_m < cppr_c;
        end
      end else if (busy && scan_ack) begin
        busy           <= 1'b0;
        lsmfb_q[sel_q] <= scan_prio;
        if (scan_prio != MASK) begin
          dec_req     <= 1'b1;
          dec_prio    <= scan_prio;
          dec_level   <= scan_level;
          pipr_q[tq]  <= scan_prio;
          exc[sel_q]  <= scan_prio < cppr_q[tq];
        end else begin
          exc[sel_q]  <= pipr_q[tq] < cppr_q[tq];
        end
      end
    end
  end

  assign scan_req  = busy;
  assign scan_ring = sel_q;

  logic [1:0] rd_i;
  assign rd_i     = (rd_ring == 2'd3) ? R_PHYS : rd_ring;
  assign rd_cppr  = cppr_q[rd_i];
  assign rd_pipr  = pipr_q[rd_i];
  assign rd_lsmfb = lsmfb_q[rd_i];

  assign chk_ok = (chk_ring == R_OS)   ? (chk_prio < cppr_q[R_OS]) :
                  (chk_ring == 2'd3)   ? 1'b0 :
                                         (chk_prio < cppr_q[R_PHYS]);

  a_r2_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && !wr_phys && wr_val > PW'(PRIO_MAX)) |=> cppr_q[R_OS] == MASK);

  a_r9_dec_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    dec_req |-> ($past(busy && scan_ack) && $past(scan_prio) != MASK));

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_req && !scan_ack) |=> scan_req);

  a_r8_err_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_err |-> (!scan_req && $stable(exc)));

  a_r4_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_ack) |=> $stable(exc));

  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok |-> chk_prio != MASK);
endmodule

// File: tb/thr_prio_update_test.sv
module thr_prio_update_test;
  logic clk = 0, rst_n = 0;
  logic ld_en = 0, ld_valid = 0, wr_en = 0, wr_phys = 0, scan_ack = 0;
  logic [1:0] ld_ring = 0, rd_ring = 0, chk_ring = 0;
  logic [7:0] ld_pend = 0, ld_lsmfb = 0, ld_lgs = 0, wr_val = 0, scan_prio = 0, chk_prio = 0;
  logic [3:0] scan_level = 0;
  logic busy, scan_req, dec_req, ctx_err, chk_ok;
  logic [1:0] scan_ring;
  logic [7:0] dec_prio, rd_cppr, rd_pipr, rd_lsmfb;
  logic [3:0] dec_level;
  logic [2:0] exc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  thr_prio_update uut (.*);

  task automatic ck(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [1:0] r, input logic [7:0] p, l, g, input logic v);
    @(negedge clk);
    ld_en = 1; ld_ring = r; ld_pend = p; ld_lsmfb = l; ld_lgs = g; ld_valid = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic wr(input logic ph, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_phys = ph; wr_val = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ack(input logic [7:0] p, input logic [3:0] lv);
    scan_ack = 1; scan_prio = p; scan_level = lv;
    @(negedge clk);
    scan_ack = 0;
  endtask

  task automatic rd(input logic [1:0] r);
    rd_ring = r; #0.5;
  endtask

  task automatic t_reset;
    for (int r = 0; r < 3; r++) begin
      rd(2'(r));
      ck("R1 cppr", rd_cppr, 8'h00);
      ck("R1 pipr", rd_pipr, 8'hFF);
      ck("R1 lsmfb", rd_lsmfb, 8'hFF);
    end
    ck("R1 exc", exc, 0);
    ck("R1 busy", busy, 0);
    ck("R1 dec", dec_req, 0);
    ck("R1 err", ctx_err, 0);
  endtask

  task automatic t_os_basic;
    ld(0, 8'h10, 8'hFF, 0, 1);
    wr(0, 5);
    rd(0);
    ck("R3 pipr bit4", rd_pipr, 3);
    ck("R4 exc set", exc[0], 1);
    ck("R6 no scan", busy, 0);
    wr(0, 2);
    ck("R4 exc clear", exc[0], 0);
    wr(0, 9);
    rd(0);
    ck("R2 clamp", rd_cppr, 8'hFF);
    ck("R4 exc masked", exc[0], 1);
  endtask

  task automatic t_invalid;
    ld(0, 8'h10, 8'hFF, 0, 0);
    wr(0, 2);
    rd(0);
    ck("R8 err pulse", ctx_err, 1);
    ck("R8 cppr stored", rd_cppr, 2);
    ck("R8 exc kept", exc[0], 1);
    @(negedge clk);
    ck("R8 err one cycle", ctx_err, 0);
  endtask

  task automatic t_pool_merge;
    ld(2, 8'h02, 8'hFF, 0, 1);
    ld(1, 8'h20, 8'hFF, 0, 1);
    wr(1, 4);
    rd(2);
    ck("R5 merged pipr", rd_pipr, 2);
    ck("R5 pool selected", exc[1], 1);
    ck("R5 phys line", exc[2], 0);
    ld(1, 8'h20, 8'hFF, 0, 0);
    wr(1, 7);
    rd(2);
    ck("R5 pool ignored", rd_pipr, 6);
    ck("R5 phys selected", exc[2], 1);
  endtask

  task automatic t_scan;
    ld(0, 8'h01, 8'h01, 1, 1);
    wr(0, 0);
    ck("R6 no scan cppr0", busy, 0);
    ck("R4 exc0 clear", exc[0], 0);
    wr(0, 4);
    ck("R6 scan req", scan_req, 1);
    ck("R6 scan ring", scan_ring, 0);
    wr(0, 6);
    rd(0);
    ck("R11 write ignored", rd_cppr, 4);
    ck("R11 req held", scan_req, 1);
    ack(8'h02, 4'd3);
    rd(0);
    ck("R9 dec", dec_req, 1);
    ck("R9 dec prio", dec_prio, 2);
    ck("R9 dec level", dec_level, 3);
    ck("R9 lsmfb", rd_lsmfb, 2);
    ck("R9 pipr", rd_pipr, 2);
    ck("R4 exc after scan", exc[0], 1);
    ck("R11 idle", busy, 0);
    @(negedge clk);
    ck("R9 dec one cycle", dec_req, 0);
    wr(0, 5);
    ck("R6 scan again", scan_req, 1);
    ack(8'hFF, 4'd1);
    rd(0);
    ck("R9 empty no dec", dec_req, 0);
    ck("R9 lsmfb empty", rd_lsmfb, 8'hFF);
    ck("R9 pipr local", rd_pipr, 7);
    ck("R4 exc after empty", exc[0], 0);
    ld(0, 8'h01, 8'h05, 1, 1);
    wr(0, 3);
    ck("R6 lsmfb not below cppr", busy, 0);
    ld(0, 8'h01, 8'h01, 0, 1);
    wr(0, 4);
    ck("R6 group disabled", busy, 0);
  endtask

  task automatic t_pool_group;
    ld(1, 8'h00, 8'h01, 1, 1);
    ld(2, 8'h02, 8'hFF, 0, 1);
    wr(1, 0);
    ck("R7 pool exc cleared", exc[1], 0);
    wr(1, 5);
    ck("R7 scan req", scan_req, 1);
    ck("R7 scan pool", scan_ring, 1);
    ack(8'h00, 4'd2);
    rd(1);
    ck("R7 pool lsmfb", rd_lsmfb, 0);
    rd(2);
    ck("R7 phys pipr", rd_pipr, 0);
    ck("R7 pool exc", exc[1], 1);
  endtask

  task automatic t_preclude;
    chk_ring = 2; chk_prio = 4; #0.5;
    ck("R10 phys taken", chk_ok, 1);
    chk_prio = 5; #0.5;
    ck("R10 phys equal", chk_ok, 0);
    chk_ring = 1; chk_prio = 4; #0.5;
    ck("R10 pool uses phys", chk_ok, 1);
    chk_ring = 0; chk_prio = 4; #0.5;
    ck("R10 os equal", chk_ok, 0);
    chk_prio = 3; #0.5;
    ck("R10 os taken", chk_ok, 1);
    chk_ring = 3; chk_prio = 0; #0.5;
    ck("R10 ring3", chk_ok, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_os_basic;
    t_invalid;
    t_pool_merge;
    t_scan;
    t_pool_group;
    t_preclude;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule